// File: doc/BRIEF.md
# LCD Pixel FIFO and Unpacker

This block sits between the frame-buffer fetch path of a display controller and its palette and colour pipeline. A fetch engine writes 32-bit frame-buffer words into a sixteen-entry FIFO. The block raises a DMA request while enough entries are free, with a selectable threshold. Each buffered word is split into a stream of pixels at 1, 2, 4, 8 or 16 bits per pixel. Separate controls set the order in which the bytes of a word are consumed and the order of the pixels packed inside one byte.

At 1 to 8 bits per pixel the output is a raw palette index, zero-extended on a 24-bit bus. At 16 bits per pixel each half-word is read as 5:6:5 and widened to 8:8:8 by replicating its top bits, with an optional swap of red and blue. Pixels leave on a valid/ready handshake. A power-enable input forces the data lines to zero while it is low. Format, byte order and pixel order are latched only while the FIFO is empty, so one word is never split across two settings. The colour swap and the power gate act on every cycle.

Top module: `lcdpu_top`

## Requirements
- R1: The FIFO holds 16 words. A write (`wr_valid` high for one cycle) is stored only if the FIFO is not full. A write to a full FIFO is dropped and never appears at the output.
- R2: `dma_req` is 1 while the number of free entries is at least 4 (`wm_sel`=0) or at least 8 (`wm_sel`=1). It tracks the fill level in the same cycle.
- R3: `pix_fmt` selects 0=1 bpp, 1=2 bpp, 2=4 bpp, 3=8 bpp, 4=16 bpp, and values 5 to 7 act as 16 bpp. Each word gives 32/bpp pixels. The word leaves the FIFO in the cycle its last pixel is accepted (`pix_valid` and `pix_ready` both high).
- R4: With `byte_be`=0 the bytes of a word are consumed from bits [7:0] upward. With `byte_be`=1 they are consumed from bits [31:24] downward. At 16 bpp, pixel k takes its low byte from consumed byte 2k and its high byte from consumed byte 2k+1.
- R5: At 1, 2 and 4 bpp, `pix_msb`=0 takes the pixels of a byte starting at bit 0, and `pix_msb`=1 takes them starting at bit 7. At 8 and 16 bpp `pix_msb` has no effect.
- R6: At 1 to 8 bpp, `pix_data` carries the index in its low bits and zeros above it, whatever the value of `rb_swap`.
- R7: At 16 bpp a half-word h gives red {h[15:11],h[15:13]} on `pix_data`[23:16], green {h[10:5],h[10:9]} on [15:8] and blue {h[4:0],h[4:2]} on [7:0].
- R8: At 16 bpp with `rb_swap`=1, the red and blue bytes of `pix_data` trade places.
- R9: While `pwr_en` is 0, `pix_data` is zero. The handshake keeps working.
- R10: While `pix_valid` is 1 and `pix_ready` is 0, `pix_valid` stays 1 and `pix_data` stays unchanged, provided `pwr_en` does not change.
- R11: `pix_fmt`, `byte_be` and `pix_msb` take effect only while the FIFO is empty. Changes made while words are buffered do not alter those words.
- R12: After reset the FIFO is empty, `pix_valid` is 0 and `dma_req` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_valid | input | 1 | Write one word into the FIFO |
| wr_data | input | 32 | Frame-buffer word |
| dma_req | output | 1 | Request for more words |
| wm_sel | input | 1 | Free-entry threshold: 0 means 4, 1 means 8 |
| pix_fmt | input | 3 | Bits-per-pixel code |
| byte_be | input | 1 | Byte consumption order |
| pix_msb | input | 1 | Pixel order within a byte |
| rb_swap | input | 1 | Red/blue exchange at 16 bpp |
| pwr_en | input | 1 | Data-line enable |
| pix_valid | output | 1 | Pixel available |
| pix_ready | input | 1 | Consumer accepts the pixel |
| pix_data | output | 24 | Index or RGB colour |

## Verification
The checker keeps its own count of stored words. It assumes that a write is taken whenever that count is below sixteen and that `pwr_en` may toggle at any time. The hold property assumes that `pwr_en` is steady across a stalled cycle, and the bench changes `pwr_en` only for the gating check. The bench drives controls and writes only on falling edges. It changes format and order controls only while the FIFO is empty, except in the one test that checks that such changes are ignored. Its ready pattern mixes accepted and stalled cycles, so that pops are checked both back to back and after a stall.

// File: rtl/lcdpu_pkg.sv
package lcdpu_pkg;

   typedef enum logic [2:0] {
      FMT_B1  = 3'd0,
      FMT_B2  = 3'd1,
      FMT_B4  = 3'd2,
      FMT_B8  = 3'd3,
      FMT_B16 = 3'd4
   } fmt_e;

   typedef struct packed {
      fmt_e fmt;
      logic byte_be;
      logic pix_msb;
   } ucfg_t;

   function automatic fmt_e fmt_clamp(input logic [2:0] code);
      return (code > 3'd4) ? FMT_B16 : fmt_e'(code);
   endfunction

endpackage

// File: rtl/lcdpu_fifo.sv
module lcdpu_fifo #(
   parameter int W     = 32,
   parameter int DEPTH = 16,
   localparam int AW   = $clog2(DEPTH),
   localparam int LW   = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          push,
   input  logic [W-1:0]  din,
   input  logic          pop,
   output logic [W-1:0]  dout,
   output logic          empty,
   output logic          full,
   output logic [LW-1:0] level
);

   logic [W-1:0]  mem [DEPTH];
   logic [AW-1:0] rd_p, wr_p;
   logic          do_push, do_pop;

   assign full    = (level == LW'(DEPTH));
   assign empty   = (level == '0);
   assign do_push = push && !full;
   assign do_pop  = pop && !empty;
   assign dout    = mem[rd_p];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_p  <= '0;
         wr_p  <= '0;
         level <= '0;
      end else begin
         if (do_push) wr_p <= wr_p + 1'b1;
         if (do_pop)  rd_p <= rd_p + 1'b1;
         case ({do_push, do_pop})
            2'b10:   level <= level + 1'b1;
            2'b01:   level <= level - 1'b1;
            default: level <= level;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (do_push) mem[wr_p] <= din;
   end

endmodule

// File: rtl/lcdpu_unpack.sv
module lcdpu_unpack
   import lcdpu_pkg::*;
#(
   parameter int W   = 32,
   localparam int NB = W / 8,
   localparam int IW = $clog2(W)
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] word,
   input  logic         word_ok,
   input  ucfg_t        cfg,
   input  logic         ready,
   output logic         valid,
   output logic [15:0]  raw,
   output logic         is16,
   output logic         pop
);

   logic [W-1:0]  strm;
   logic [W-1:0]  fld;
   logic [2:0]    lg;
   logic [IW-1:0] idx, off, offm, last_idx;
   logic [2:0]    top_pos;
   logic [16:0]   mask;
   logic          last;

   // consumed byte order
   for (genvar i = 0; i < NB; i++) begin : g_bytes
      assign strm[8*i +: 8] = cfg.byte_be ? word[8*(NB-1-i) +: 8] : word[8*i +: 8];
   end

   assign lg       = cfg.fmt;
   assign is16     = (cfg.fmt == FMT_B16);
   assign off      = idx << lg;
   assign top_pos  = 3'(4'd8 - (4'd1 << lg));
   assign last_idx = IW'((W >> lg) - 1);
   assign last     = (idx == last_idx);
   assign mask     = (17'd1 << (5'd1 << lg)) - 17'd1;

   always_comb begin
      offm = off;
      if (cfg.pix_msb && (lg < 3'd3))
         offm = {off[IW-1:3], 3'(top_pos - off[2:0])};
   end

   assign fld   = strm >> offm;
   assign raw   = fld[15:0] & mask[15:0];
   assign valid = word_ok;
   assign pop   = valid && ready && last;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)               idx <= '0;
      else if (valid && ready)  idx <= last ? '0 : idx + 1'b1;
   end

endmodule

// File: rtl/lcdpu_color.sv
module lcdpu_color #(
   parameter bit REPLICATE = 1'b1
) (
   input  logic [15:0] raw,
   input  logic        is16,
   input  logic        swap,
   input  logic        pwr,
   output logic [23:0] pix
);

   logic [7:0] r8, g8, b8;

   if (REPLICATE) begin : g_repl
      assign r8 = {raw[15:11], raw[15:13]};
      assign g8 = {raw[10:5],  raw[10:9]};
      assign b8 = {raw[4:0],   raw[4:2]};
   end else begin : g_zero
      assign r8 = {raw[15:11], 3'd0};
      assign g8 = {raw[10:5],  2'd0};
      assign b8 = {raw[4:0],   3'd0};
   end

   always_comb begin
      if (!pwr)       pix = '0;
      else if (is16)  pix = swap ? {b8, g8, r8} : {r8, g8, b8};
      else            pix = {8'd0, raw};
   end

endmodule

// File: rtl/lcdpu_top.sv
module lcdpu_top
   import lcdpu_pkg::*;
#(
   parameter int DEPTH     = 16,
   parameter int WM_LO     = 4,
   parameter int WM_HI     = 8,
   parameter bit REPLICATE = 1'b1,
   localparam int W        = 32,
   localparam int LW       = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_valid,
   input  logic [W-1:0]  wr_data,
   output logic          dma_req,
   input  logic          wm_sel,
   input  logic [2:0]    pix_fmt,
   input  logic          byte_be,
   input  logic          pix_msb,
   input  logic          rb_swap,
   input  logic          pwr_en,
   output logic          pix_valid,
   input  logic          pix_ready,
   output logic [23:0]   pix_data
);

   if ((DEPTH & (DEPTH - 1)) != 0 || DEPTH < 2) begin : g_bad_depth
      $error("lcdpu_top: DEPTH must be a power of two");
   end
   if (WM_LO > WM_HI || WM_HI > DEPTH) begin : g_bad_wm
      $error("lcdpu_top: watermarks out of range");
   end

   logic [W-1:0]  head;
   logic          f_empty, f_full, f_pop;
   logic [LW-1:0] f_level;
   logic [LW-1:0] f_free;
   ucfg_t         cfg_q;
   logic [15:0]   raw;
   logic          is16;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cfg_q <= '{fmt: FMT_B1, byte_be: 1'b0, pix_msb: 1'b0};
      else if (f_empty)
         cfg_q <= '{fmt: fmt_clamp(pix_fmt), byte_be: byte_be, pix_msb: pix_msb};
   end

   lcdpu_fifo #(.W(W), .DEPTH(DEPTH)) u_fifo (
      .clk(clk), .rst_n(rst_n),
      .push(wr_valid), .din(wr_data),
      .pop(f_pop), .dout(head),
      .empty(f_empty), .full(f_full), .level(f_level)
   );

   assign f_free  = LW'(DEPTH) - f_level;
   assign dma_req = wm_sel ? (f_free >= LW'(WM_HI)) : (f_free >= LW'(WM_LO));

   lcdpu_unpack #(.W(W)) u_unp (
      .clk(clk), .rst_n(rst_n),
      .word(head), .word_ok(!f_empty), .cfg(cfg_q),
      .ready(pix_ready), .valid(pix_valid),
      .raw(raw), .is16(is16), .pop(f_pop)
   );

   lcdpu_color #(.REPLICATE(REPLICATE)) u_col (
      .raw(raw), .is16(is16), .swap(rb_swap), .pwr(pwr_en), .pix(pix_data)
   );

endmodule

// File: rtl/lcdpu_chk.sv
module lcdpu_chk #(
   parameter int DEPTH = 16,
   parameter int WM_LO = 4,
   parameter int WM_HI = 8,
   localparam int LW   = $clog2(DEPTH + 1)
) (
   input logic          clk,
   input logic          rst_n,
   input logic          wr_valid,
   input logic          wm_sel,
   input logic          pwr_en,
   input logic          pix_valid,
   input logic          pix_ready,
   input logic [23:0]   pix_data,
   input logic          dma_req,
   input logic          f_pop,
   input logic [LW-1:0] f_level,
   input logic [4:0]    cfg_bits
);

   logic [LW-1:0] occ;
   logic          occ_in, occ_out;

   assign occ_in  = wr_valid && (occ < LW'(DEPTH));
   assign occ_out = f_pop;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) occ <= '0;
      else        occ <= occ + LW'(occ_in) - LW'(occ_out);
   end

   assert_no_overflow_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (f_level == occ) && (f_level <= LW'(DEPTH)));

   assert_dma_level_R2: assert property (@(posedge clk) disable iff (!rst_n)
      dma_req == ((DEPTH - int'(occ)) >= (wm_sel ? WM_HI : WM_LO)));

   assert_pop_on_accept_R3: assert property (@(posedge clk) disable iff (!rst_n)
      f_pop |-> (pix_valid && pix_ready));

   assert_power_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !pwr_en |-> (pix_data == 24'd0));

   assert_stall_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (pix_valid && !pix_ready && pwr_en) |=> (pix_valid && (!pwr_en || $stable(pix_data))));

   assert_cfg_frozen_R11: assert property (@(posedge clk) disable iff (!rst_n)
      pix_valid |=> (!pix_valid || $stable(cfg_bits)));

   assert_reset_state_R12: assert property (@(posedge clk)
      !rst_n |-> (!pix_valid && dma_req));

endmodule

bind lcdpu_top lcdpu_chk #(.DEPTH(DEPTH), .WM_LO(WM_LO), .WM_HI(WM_HI)) u_chk (
   .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wm_sel(wm_sel),
   .pwr_en(pwr_en), .pix_valid(pix_valid), .pix_ready(pix_ready),
   .pix_data(pix_data), .dma_req(dma_req), .f_pop(f_pop),
   .f_level(f_level), .cfg_bits(cfg_q)
);

// File: tb/tb_lcdpu_top.sv
module tb_lcdpu_top;

   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        wr_valid;
   logic [31:0] wr_data;
   logic        dma_req;
   logic        wm_sel;
   logic [2:0]  pix_fmt;
   logic        byte_be;
   logic        pix_msb;
   logic        rb_swap;
   logic        pwr_en;
   logic        pix_valid;
   logic        pix_ready;
   logic [23:0] pix_data;

   int          total = 0;
   int          bad   = 0;
   logic [31:0] wq [32];

   always #(CLK_PERIOD / 2) clk = ~clk;

   lcdpu_top dut (
      .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_data(wr_data),
      .dma_req(dma_req), .wm_sel(wm_sel), .pix_fmt(pix_fmt),
      .byte_be(byte_be), .pix_msb(pix_msb), .rb_swap(rb_swap),
      .pwr_en(pwr_en), .pix_valid(pix_valid), .pix_ready(pix_ready),
      .pix_data(pix_data)
   );

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [23:0] exp_pix(input logic [31:0] w, input int fmt,
                                           input bit be, input bit msb, input bit sw, input int k);
      logic [7:0]  b [4];
      logic [15:0] h;
      logic [7:0]  r, g, bl, by;
      int          bpp, per, p;
      for (int i = 0; i < 4; i++) b[i] = be ? w[8*(3-i) +: 8] : w[8*i +: 8];
      bpp = 1 << fmt;
      if (fmt >= 4) begin
         h  = {b[2*k+1], b[2*k]};
         r  = {h[15:11], h[15:13]};
         g  = {h[10:5], h[10:9]};
         bl = {h[4:0], h[4:2]};
         return sw ? {bl, g, r} : {r, g, bl};
      end
      if (fmt == 3) return {16'd0, b[k]};
      per = 8 / bpp;
      by  = b[k / per];
      p   = k % per;
      if (msb) by = by >> (8 - bpp * (p + 1));
      else     by = by >> (bpp * p);
      return {16'd0, by & 8'((1 << bpp) - 1)};
   endfunction

   task automatic push(input logic [31:0] w);
      @(negedge clk);
      wr_valid = 1'b1;
      wr_data  = w;
      @(negedge clk);
      wr_valid = 1'b0;
   endtask

   task automatic drain(input int nw, input int fmt, input bit be, input bit msb,
                        input bit sw, input string tag);
      int ppw, tot, got, cyc;
      ppw = 32 >> fmt;
      tot = nw * ppw;
      got = 0;
      cyc = 0;
      while (got < tot && cyc < 8000) begin
         @(negedge clk);
         pix_ready = ((cyc % 3) != 1);
         #1;
         if (pix_valid && pix_ready) begin
            chk(pix_data == exp_pix(wq[got / ppw], fmt, be, msb, sw, got % ppw),
                tag, {8'd0, pix_data}, {8'd0, exp_pix(wq[got / ppw], fmt, be, msb, sw, got % ppw)});
            got++;
         end
         cyc++;
      end
      @(negedge clk);
      pix_ready = 1'b0;
      #1;
      chk(got == tot, "R3 pixel count", got, tot);
      chk(!pix_valid, "R3 word popped after last pixel", {31'd0, pix_valid}, 32'd0);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      bad++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      rst_n = 1'b0; wr_valid = 1'b0; wr_data = '0; wm_sel = 1'b0; pix_fmt = 3'd0;
      byte_be = 1'b0; pix_msb = 1'b0; rb_swap = 1'b0; pwr_en = 1'b1; pix_ready = 1'b0;
      repeat (3) @(negedge clk);
      #1;
      chk(!pix_valid, "R12 valid after reset", {31'd0, pix_valid}, 32'd0);
      chk(dma_req, "R12 dma_req after reset", {31'd0, dma_req}, 32'd1);
      rst_n = 1'b1;
      @(negedge clk);
      #1;
      chk(!pix_valid && dma_req, "R12 state after release", {30'd0, pix_valid, dma_req}, 32'd1);

      // sweep: R3 R4 R5 R6 R7 R8 over every format and order combination
      for (int f = 0; f < 5; f++) begin
         for (int c = 0; c < 8; c++) begin
            @(negedge clk);
            pix_fmt = 3'(f);
            byte_be = c[0];
            pix_msb = c[1];
            rb_swap = c[2];
            for (int n = 0; n < 2; n++) begin
               wq[n] = 32'hA5C3_0F96 ^ (32'(n + 1) * 32'h1357_9BDF) ^ 32'((f * 8 + c) << 5);
               push(wq[n]);
            end
            drain(2, f, c[0], c[1], c[2],
                  (f == 4) ? "R4 R5 R7 R8 16bpp pixel" : "R3 R4 R5 R6 index pixel");
         end
      end

      // formats 5..7 act as 16 bpp (R3)
      @(negedge clk);
      pix_fmt = 3'd6; byte_be = 1'b0; pix_msb = 1'b0; rb_swap = 1'b0;
      wq[0] = 32'hF81F_07E0;
      push(wq[0]);
      drain(1, 4, 1'b0, 1'b0, 1'b0, "R3 clamped format");

      // fill, overflow and watermark (R1 R2)
      @(negedge clk);
      pix_fmt = 3'd4; byte_be = 1'b0; pix_msb = 1'b0; rb_swap = 1'b1;
      for (int n = 1; n <= 20; n++) begin
         int c;
         if (n <= 16) wq[n-1] = 32'h1234_8765 + 32'(n) * 32'h0101_0F0F;
         push(32'h1234_8765 + 32'(n) * 32'h0101_0F0F);
         c = (n > 16) ? 16 : n;
         wm_sel = 1'b0;
         #1;
         chk(dma_req == ((16 - c) >= 4), "R2 low watermark", {31'd0, dma_req}, {31'd0, (16 - c) >= 4});
         wm_sel = 1'b1;
         #1;
         chk(dma_req == ((16 - c) >= 8), "R2 high watermark", {31'd0, dma_req}, {31'd0, (16 - c) >= 8});
      end
      drain(16, 4, 1'b0, 1'b0, 1'b1, "R1 only first 16 words kept");

      // controls changed while buffered are ignored (R11)
      @(negedge clk);
      pix_fmt = 3'd3; byte_be = 1'b0; pix_msb = 1'b0; rb_swap = 1'b0;
      wq[0] = 32'hC0DE_4B1D;
      push(wq[0]);
      pix_fmt = 3'd0; byte_be = 1'b1; pix_msb = 1'b1;
      drain(1, 3, 1'b0, 1'b0, 1'b0, "R11 latched format");

      // power gate (R9) and stall hold (R10)
      @(negedge clk);
      pix_fmt = 3'd4; byte_be = 1'b0; pix_msb = 1'b0; rb_swap = 1'b0;
      wq[0] = 32'h7BEF_FFFF;
      push(wq[0]);
      pwr_en = 1'b0;
      #1;
      chk(pix_data == 24'd0, "R9 data gated", {8'd0, pix_data}, 32'd0);
      chk(pix_valid, "R9 valid while gated", {31'd0, pix_valid}, 32'd1);
      pwr_en = 1'b1;
      #1;
      chk(pix_data == exp_pix(wq[0], 4, 1'b0, 1'b0, 1'b0, 0), "R9 data restored",
          {8'd0, pix_data}, {8'd0, exp_pix(wq[0], 4, 1'b0, 1'b0, 1'b0, 0)});
      for (int s = 0; s < 5; s++) begin
         @(negedge clk);
         #1;
         chk(pix_valid && pix_data == exp_pix(wq[0], 4, 1'b0, 1'b0, 1'b0, 0), "R10 stalled hold",
             {8'd0, pix_data}, {8'd0, exp_pix(wq[0], 4, 1'b0, 1'b0, 1'b0, 0)});
      end
      drain(1, 4, 1'b0, 1'b0, 1'b0, "R7 after stall");

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule